// File: doc/BRIEF.md
# Sprite Scanline Evaluator

This block picks the sprites that touch one raster line. On a line-start pulse it walks a 64-entry sprite attribute table in index order, one entry per clock, reading the four 16-bit words of the current entry over a combinational read port. Each entry that overlaps the line becomes one or two sprite units of 16 pixels. Each unit carries the screen x position, the pattern number with the row already folded in, the 4-bit sub-row, the palette, the priority and horizontal flip bits, and a tag that marks units from entry 0. The downstream pattern fetcher needs the tag for its collision test.

Units go into a 16-deep buffer in table order. The buffer is read by index and shows the unit count. When a seventeenth unit turns up, the scan stops. An overflow flag is raised only if the overflow enable input is high. A done flag marks the end of the scan and holds until the next line-start pulse.

The controller has three states. IDLE is entered from reset and left on a line-start pulse, which goes to SCAN. SCAN handles one entry per cycle. It goes to DONE after entry 63 or on the unit that exceeds the limit. A line-start pulse in SCAN restarts the scan and stays in SCAN. DONE holds its results until a line-start pulse, which goes to SCAN.

Top module: `sprite_line_eval`

## Requirements
- R1: Entry fields are decoded as follows:
  - word 0 bits 9:0 are the top line plus 64, so Y = value − 64.
  - word 1 bits 9:0 are X.
  - word 2 bits 10:1 are the pattern number.
  - word 3 holds the palette in bits 3:0, priority in bit 7, the wide flag in bit 8, horizontal flip in bit 11, the height code in bits 13:12 and vertical flip in bit 15.
- R2: Height code 0 means 16 lines, 1 means 32, and 2 or 3 means 64. An entry overlaps the line when (line − Y), taken modulo 2^16, is below its height.
- R3: The row offset is (line − Y), or height − 1 − offset when vertical flip is set. Before use, the pattern number has bit 1 cleared for height 32 and bits 2:1 cleared for height 64. Row bits 5:4 are then ORed into pattern bits 2:1, and row bits 3:0 give the sub-row.
- R4: A wide entry gives two units in the same cycle. The first sits at X with pattern LSB 0, and the second at X+16 (11-bit x) with pattern LSB 1. Horizontal flip swaps the two LSBs. A narrow entry keeps its own LSB and an x of X.
- R5: Units are stored in table order from buffer slot 0 upward, and the unit count output equals the number stored.
- R6: The scan stops when a unit is found while 16 are already stored. If a wide entry arrives with only one slot free, its first unit is kept. The overflow output rises at that point only when the overflow enable is high. The count never exceeds 16.
- R7: Every unit that comes from entry 0 has its first-entry tag set, and all other units have it clear.
- R8: The scan handles one entry per cycle. Without a stop, done rises 65 clocks after the clock that samples line start. After a stop at entry k it rises k+2 clocks after that clock. Done then holds with a stable count until the next pulse.
- R9: After reset, and in the cycle after any line-start pulse, the count is 0 and done and overflow are low. A pulse during a scan discards the partial result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse that starts a scan |
| line_num | input | 10 | Raster line sampled with line_start |
| ovf_en | input | 1 | Allows the overflow flag to be set |
| ent_idx | output | 6 | Table entry being read |
| ent_w0 | input | 16 | Word 0 of the addressed entry |
| ent_w1 | input | 16 | Word 1 of the addressed entry |
| ent_w2 | input | 16 | Word 2 of the addressed entry |
| ent_w3 | input | 16 | Word 3 of the addressed entry |
| done | output | 1 | Scan finished; results valid |
| unit_count | output | 5 | Units stored |
| overflow | output | 1 | Unit limit was exceeded while enabled |
| rd_idx | input | 4 | Buffer slot to read |
| rd_x | output | 11 | Unit x position |
| rd_pat | output | 10 | Unit pattern number with row bits |
| rd_sub | output | 4 | Unit sub-row |
| rd_pal | output | 4 | Unit palette |
| rd_prio | output | 1 | Unit priority |
| rd_hflip | output | 1 | Unit horizontal flip |
| rd_first | output | 1 | Unit came from entry 0 |

## Verification
The first table mixes all three heights, the two vertical orientations, narrow and wide sprites with and without horizontal flip, and an x near the top of the range. Its sprites sit exactly at the last covered line, one line past it, and one line above their top. This separates a correct unsigned overlap test from a signed or off-by-one one, and shows whether row folding, pattern masking and LSB swapping act per field. A crowded table is run with the overflow enable high and low. It tells whether the stop point, the partial wide unit and the flag are gated separately. A pulse during a scan, and a scan whose last entry hits, confirm the restart and the full 64-entry sweep timing.

// File: rtl/sle_pkg.sv
package sle_pkg;
    localparam int COORD_W = 10;
    localparam int X_W     = COORD_W + 1;
    localparam int PAT_W   = 10;
    localparam int SUB_W   = 4;
    localparam int PAL_W   = 4;
    localparam int WORD_W  = 16;

    typedef struct packed {
        logic [X_W-1:0]   x;
        logic [PAT_W-1:0] pat;
        logic [SUB_W-1:0] sub;
        logic [PAL_W-1:0] pal;
        logic             prio;
        logic             hflip;
        logic             first;
    } unit_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;
endpackage

// File: rtl/sle_entry_decode.sv
module sle_entry_decode
    import sle_pkg::*;
(
    input  logic [COORD_W-1:0] line_num,
    input  logic               is_first,
    input  logic [WORD_W-1:0]  w0,
    input  logic [WORD_W-1:0]  w1,
    input  logic [WORD_W-1:0]  w2,
    input  logic [WORD_W-1:0]  w3,
    output logic               hit,
    output logic               wide,
    output unit_t              unit_a,
    output unit_t              unit_b
);
    logic [WORD_W-1:0] ytop, diff;
    logic [6:0]        hgt, row;
    logic [PAT_W-1:0]  base;
    logic              vflip, hflip;
    logic              unused_bits;

    assign unused_bits = ^{w0[15:10], w1[15:10], w2[15:11], w2[0],
                           w3[6:4], w3[10:9], w3[14], row[6]};

    always_comb begin
        vflip = w3[15];
        hflip = w3[11];
        wide  = w3[8];
        ytop  = {6'd0, w0[9:0]} - 16'd64;
        diff  = {6'd0, line_num} - ytop;
        unique case (w3[13:12])
            2'd0:    hgt = 7'd16;
            2'd1:    hgt = 7'd32;
            default: hgt = 7'd64;
        endcase
        hit  = diff < {9'd0, hgt};
        row  = vflip ? (hgt - 7'd1 - diff[6:0]) : diff[6:0];
        base = w2[10:1];
        unique case (w3[13:12])
            2'd0:    ;
            2'd1:    base[1]   = 1'b0;
            default: base[2:1] = 2'b00;
        endcase
        base[2:1] = base[2:1] | row[5:4];

        unit_a.x     = {1'b0, w1[9:0]};
        unit_a.pat   = wide ? {base[PAT_W-1:1], hflip} : base;
        unit_a.sub   = row[3:0];
        unit_a.pal   = w3[3:0];
        unit_a.prio  = w3[7];
        unit_a.hflip = hflip;
        unit_a.first = is_first;

        unit_b       = unit_a;
        unit_b.x     = {1'b0, w1[9:0]} + 11'd16;
        unit_b.pat   = {base[PAT_W-1:1], ~hflip};
    end
endmodule

// File: rtl/sle_unit_buf.sv
module sle_unit_buf
    import sle_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_a,
    input  logic [AW-1:0] addr_a,
    input  unit_t         d_a,
    input  logic          we_b,
    input  logic [AW-1:0] addr_b,
    input  unit_t         d_b,
    input  logic [AW-1:0] rd_addr,
    output unit_t         rd_data
);
    unit_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (we_a && addr_a == AW'(g))
                slots[g] <= d_a;
            else if (we_b && addr_b == AW'(g))
                slots[g] <= d_b;
        end
    end

    assign rd_data = slots[rd_addr];

    AST_PAIR_SLOTS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && we_b) |-> (addr_b == addr_a + AW'(1)));   // R4
    AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        we_b |-> we_a);   // R6
endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
    import sle_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int MAX_UNITS   = 16,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int CNT_W      = $clog2(MAX_UNITS + 1),
    localparam int BUF_AW     = $clog2(MAX_UNITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic [COORD_W-1:0] line_num,
    input  logic               ovf_en,
    output logic [IDX_W-1:0]   ent_idx,
    input  logic [WORD_W-1:0]  ent_w0,
    input  logic [WORD_W-1:0]  ent_w1,
    input  logic [WORD_W-1:0]  ent_w2,
    input  logic [WORD_W-1:0]  ent_w3,
    output logic               done,
    output logic [CNT_W-1:0]   unit_count,
    output logic               overflow,
    input  logic [BUF_AW-1:0]  rd_idx,
    output logic [X_W-1:0]     rd_x,
    output logic [PAT_W-1:0]   rd_pat,
    output logic [SUB_W-1:0]   rd_sub,
    output logic [PAL_W-1:0]   rd_pal,
    output logic               rd_prio,
    output logic               rd_hflip,
    output logic               rd_first
);
    scan_state_t        state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic [CNT_W-1:0]   cnt_q, room, n_new;
    logic [COORD_W-1:0] line_q;
    logic               ovf_q;
    logic               hit, wide, scanning, we_a, we_b, over, last;
    unit_t              unit_a, unit_b, rd_unit;

    sle_entry_decode u_dec (
        .line_num (line_q),
        .is_first (idx_q == '0),
        .w0       (ent_w0),
        .w1       (ent_w1),
        .w2       (ent_w2),
        .w3       (ent_w3),
        .hit      (hit),
        .wide     (wide),
        .unit_a   (unit_a),
        .unit_b   (unit_b)
    );

    sle_unit_buf #(.DEPTH(MAX_UNITS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_a    (we_a),
        .addr_a  (cnt_q[BUF_AW-1:0]),
        .d_a     (unit_a),
        .we_b    (we_b),
        .addr_b  (cnt_q[BUF_AW-1:0] + BUF_AW'(1)),
        .d_b     (unit_b),
        .rd_addr (rd_idx),
        .rd_data (rd_unit)
    );

    always_comb begin
        scanning = (state_q == ST_SCAN) && !line_start;
        room     = CNT_W'(MAX_UNITS) - cnt_q;
        n_new    = hit ? (wide ? CNT_W'(2) : CNT_W'(1)) : '0;
        we_a     = scanning && hit && (room != '0);
        we_b     = scanning && hit && wide && (room >= CNT_W'(2));
        over     = scanning && (n_new > room);
        last     = idx_q == IDX_W'(NUM_ENTRIES - 1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (line_start) state_d = ST_SCAN;
            ST_SCAN: begin
                if (line_start)          state_d = ST_SCAN;
                else if (over || last)   state_d = ST_DONE;
            end
            ST_DONE: if (line_start) state_d = ST_SCAN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (line_start) begin
                idx_q  <= '0;
                cnt_q  <= '0;
                ovf_q  <= 1'b0;
                line_q <= line_num;
            end else if (state_q == ST_SCAN) begin
                cnt_q <= cnt_q + CNT_W'(we_a) + CNT_W'(we_b);
                if (!last && !over) idx_q <= idx_q + IDX_W'(1);
                if (over) ovf_q <= ovf_en;
            end
        end
    end

    always_comb begin
        ent_idx    = idx_q;
        done       = state_q == ST_DONE;
        unit_count = cnt_q;
        overflow   = ovf_q;
        rd_x       = rd_unit.x;
        rd_pat     = rd_unit.pat;
        rd_sub     = rd_unit.sub;
        rd_pal     = rd_unit.pal;
        rd_prio    = rd_unit.prio;
        rd_hflip   = rd_unit.hflip;
        rd_first   = rd_unit.first;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        unit_count <= CNT_W'(MAX_UNITS));   // R6
    AST_OVF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(ovf_en));   // R6
    AST_OVF_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> done);   // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (unit_count == '0 && !done && !overflow));   // R9
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !line_start) |=> (done && $stable(unit_count)));   // R8
    AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !line_start) |=> unit_count >= $past(unit_count));   // R5
endmodule

// File: tb/sim_sprite_line_eval.sv
module sim_sprite_line_eval;
    typedef struct {
        int x, pat, sub, pal, prio, hflip, first;
    } exp_unit_t;

    logic        clk = 0, rst_n = 0, line_start = 0, ovf_en = 0;
    logic [9:0]  line_num = '0;
    logic [5:0]  ent_idx;
    logic [15:0] ent_w0, ent_w1, ent_w2, ent_w3;
    logic        done, overflow, rd_prio, rd_hflip, rd_first;
    logic [4:0]  unit_count;
    logic [3:0]  rd_idx = '0, rd_sub, rd_pal;
    logic [10:0] rd_x;
    logic [9:0]  rd_pat;

    logic [15:0] tbl [64][4];
    exp_unit_t   exp_q [$];
    int exp_cnt, exp_ovf, exp_cyc, mon_runs, run_cnt;
    int n_tests = 0, n_fail = 0;

    assign ent_w0 = tbl[ent_idx][0];
    assign ent_w1 = tbl[ent_idx][1];
    assign ent_w2 = tbl[ent_idx][2];
    assign ent_w3 = tbl[ent_idx][3];

    always #4 clk = ~clk;

    sprite_line_eval u0 (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clear_tbl();
        for (int e = 0; e < 64; e++)
            for (int w = 0; w < 4; w++) tbl[e][w] = '0;
    endtask

    task automatic put(input int e, input int y, input int x, input int pat, input int pal,
                       input int prio, input int wide, input int hf, input int hc, input int vf);
        tbl[e][0] = 16'((y + 64) & 10'h3FF);
        tbl[e][1] = 16'(x);
        tbl[e][2] = 16'(pat << 1);
        tbl[e][3] = 16'(pal | (prio << 7) | (wide << 8) | (hf << 11) | (hc << 12) | (vf << 15));
    endtask

    // reference built from the requirement text
    task automatic model(input int ln, input bit en);
        int n = 0;
        bit stop = 0;
        exp_q.delete();
        exp_ovf = 0;
        exp_cyc = 65;
        for (int e = 0; e < 64 && !stop; e++) begin
            int y, h, d, r, p, code, nu;
            code = int'(tbl[e][3][13:12]);
            y = int'(tbl[e][0][9:0]) - 64;
            h = (code == 0) ? 16 : (code == 1) ? 32 : 64;
            d = (ln - y) & 16'hFFFF;
            if (d >= h) continue;
            r = tbl[e][3][15] ? (h - 1 - d) : d;
            p = int'(tbl[e][2][10:1]);
            if (h == 32) p = p & ~2;
            if (h == 64) p = p & ~6;
            p = p | (((r >> 4) & 3) << 1);
            nu = tbl[e][3][8] ? 2 : 1;
            for (int k = 0; k < nu; k++) begin
                exp_unit_t u;
                if (n == 16) begin
                    stop = 1;
                    exp_ovf = en;
                    exp_cyc = e + 2;
                    break;
                end
                u.x = int'(tbl[e][1][9:0]) + 16 * k;
                u.pat = (nu == 2) ? ((p & ~1) | (k ^ int'(tbl[e][3][11]))) : p;
                u.sub = r & 15;
                u.pal = int'(tbl[e][3][3:0]);
                u.prio = int'(tbl[e][3][7]);
                u.hflip = int'(tbl[e][3][11]);
                u.first = (e == 0);
                exp_q.push_back(u);
                n++;
            end
        end
        exp_cnt = n;
    endtask

    task automatic pulse(input int ln, input bit en);
        @(negedge clk);
        line_num = 10'(ln);
        ovf_en = en;
        line_start = 1;
        @(negedge clk);
        line_start = 0;
    endtask

    task automatic run_line(input int ln, input bit en);
        int cyc;
        model(ln, en);
        run_cnt++;
        pulse(ln, en);
        cyc = 1;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == exp_cyc, "R8", "cycles to done", cyc, exp_cyc);
        wait (mon_runs == run_cnt);
        repeat (3) @(negedge clk);
        chk(done == 1, "R8", "done held", int'(done), 1);
        chk(int'(unit_count) == exp_cnt, "R8", "count held", int'(unit_count), exp_cnt);
    endtask

    // monitor: pops expected units as the design presents them
    initial begin
        forever begin
            @(posedge done);
            @(negedge clk);
            chk(int'(unit_count) == exp_cnt, "R2 R5", "unit count", int'(unit_count), exp_cnt);
            chk(int'(overflow) == exp_ovf, "R6", "overflow", int'(overflow), exp_ovf);
            for (int i = 0; i < exp_cnt; i++) begin
                exp_unit_t u;
                rd_idx = 4'(i);
                #1;
                u = exp_q.pop_front();
                chk(int'(rd_x) == u.x, "R1 R4", "x", int'(rd_x), u.x);
                chk(int'(rd_pat) == u.pat, "R3 R4", "pattern", int'(rd_pat), u.pat);
                chk(int'(rd_sub) == u.sub, "R3", "sub-row", int'(rd_sub), u.sub);
                chk(int'(rd_pal) == u.pal && int'(rd_prio) == u.prio && int'(rd_hflip) == u.hflip,
                    "R1", "pal/prio/hflip", {rd_pal, rd_prio, rd_hflip}, (u.pal << 2) | (u.prio << 1) | u.hflip);
                chk(int'(rd_first) == u.first, "R7", "entry0 tag", int'(rd_first), u.first);
            end
            mon_runs++;
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        mon_runs = 0;
        run_cnt = 0;
        clear_tbl();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(unit_count == 0 && done == 0 && overflow == 0, "R9", "reset state",
            int'({unit_count, done, overflow}), 0);

        // mixed scene
        put(0, 100, 20, 10'h015, 3, 1, 0, 0, 0, 0);
        put(1, 85, 40, 10'h021, 5, 0, 0, 1, 0, 1);
        put(2, 84, 60, 10'h030, 6, 0, 0, 0, 0, 0);
        put(3, 60, 80, 10'h3F6, 7, 1, 0, 0, 2, 1);
        put(4, 90, 1015, 10'h107, 9, 0, 1, 1, 1, 0);
        put(5, 99, 200, 10'h0AA, 2, 1, 1, 0, 0, 0);
        put(6, 101, 220, 10'h0BB, 4, 0, 0, 0, 0, 0);
        put(7, 70, 300, 10'h1FF, 8, 0, 0, 0, 3, 0);
        put(63, 95, 500, 10'h155, 15, 1, 0, 0, 0, 1);
        run_line(100, 1);
        run_line(115, 0);

        // restart during a scan
        pulse(50, 1);
        repeat (10) @(negedge clk);
        chk(done == 0 && unit_count <= 16, "R9", "mid-scan busy", int'(done), 0);
        run_line(100, 1);

        // crowded scene, wide at 15th slot
        clear_tbl();
        for (int e = 0; e < 20; e++) put(e, 30, e * 8, e + 4, e & 15, e & 1, 0, 0, 0, 0);
        put(14, 30, 400, 10'h040, 1, 0, 1, 1, 0, 0);
        run_line(30, 1);
        run_line(30, 0);

        // crowded scene, wide entry finds one free slot
        clear_tbl();
        for (int e = 0; e < 20; e++) put(e, 10, e * 8, e + 4, 2, 0, 0, 0, 0, 0);
        put(15, 10, 600, 10'h080, 3, 1, 1, 0, 0, 0);
        run_line(20, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule